// File: doc/BRIEF.md
# Sixteen-Bit Barrel Shifter with Carry-Ring Rotates

This block is the purely combinational execute stage for the shift instruction group of a small 16-bit processor. The major opcode nibble selects the group. From an instruction word it decodes an operation and a shift amount. It then shifts or rotates the operand value, which the register file supplies from the register named in bits 11:8. It returns the new value with a write enable and the destination index, plus the carry flag to store.

The amount comes from one of two places. Instruction bit 3 picks either a 4-bit immediate held in bits 7:4 or the low four bits of a second register value. The register file reads that second register at the index the block presents on `amt_idx`. Two rotates pass through the carry: they treat the carry and the 16 data bits as one 17-bit ring. The other rotates are plain 16-bit circular rotates. Only the carry rotates ever change the carry.

Top module: `bshift_unit`

## Requirements
- R1: `wr_en` is 1 exactly when `insn[15:12]` equals 4'h7, and `dst_idx` always equals `insn[11:8]`.
- R2: When `insn[3]` is 1 the amount is `insn[7:4]`. When it is 0 the amount is `amt_src[3:0]`, and `amt_src[15:4]` is ignored. `amt_idx` equals `insn[7:4]`.
- R3: An amount of zero returns `opnd` unchanged and gives `carry_out == carry_in`, whatever the operation code.
- R4: Operation code `insn[2:0]` = 0 is a logical right shift that fills the vacated top bits with zeros.
- R5: Code 1 is an arithmetic right shift that fills the vacated top bits with copies of `opnd[15]`.
- R6: Code 2 is a logical left shift that fills the vacated low bits with zeros.
- R7: Code 3 rotates the 16-bit value right and code 4 rotates it left. Bits that leave one end re-enter at the other end.
- R8: Code 5 rotates the ring {carry, data} right by n. The old carry lands at result bit 16-n and `carry_out` is `opnd[n-1]`.
- R9: Code 6 rotates the ring left by n. The old carry lands at result bit n-1 and `carry_out` is `opnd[16-n]`.
- R10: Code 7 returns `opnd` unchanged and keeps the carry unchanged.
- R11: Codes 0 to 4 never change the carry: `carry_out == carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 16 | Instruction word under execution |
| opnd | input | 16 | Value of the register named by insn[11:8] |
| amt_src | input | 16 | Value of the register named by insn[7:4] |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Shifted or rotated value |
| carry_out | output | 1 | Carry flag to store |
| wr_en | output | 1 | Result is to be written back |
| dst_idx | output | 4 | Destination register index |
| amt_idx | output | 4 | Index of the register supplying the amount |

## Verification
The checks evaluate the settled outputs of one instruction at a time. They assume the instruction word and the two register values are held steady while the block is observed, so that no partially updated inputs are compared. The bench keeps to this: it changes every input together on the falling clock edge and samples a quarter period later. Properties that hold across operations are checked only while the shift group is selected: zero fill, sign fill, preservation of the bit population, and conservation of the carry ring. Directed vectors pin down the exact values at amounts 1, 4 and 15, and also at zero.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

    localparam int INSN_W = 16;
    localparam int DATA_W = 16;
    localparam int AMT_W  = 4;
    localparam int IDX_W  = 4;

    localparam logic [3:0] GRP_SHIFT = 4'h7;

    // Field positions inside the instruction word
    localparam int GRP_LSB  = 12;
    localparam int DST_LSB  = 8;
    localparam int AMT_LSB  = 4;
    localparam int IMM_BIT  = 3;
    localparam int OP_W     = 3;

    typedef enum logic [OP_W-1:0] {
        SH_LSR  = 3'd0,
        SH_ASR  = 3'd1,
        SH_LSL  = 3'd2,
        SH_ROR  = 3'd3,
        SH_ROL  = 3'd4,
        SH_RRC  = 3'd5,
        SH_RLC  = 3'd6,
        SH_PASS = 3'd7
    } sh_op_e;

    typedef struct packed {
        logic             hit;
        sh_op_e           op;
        logic [AMT_W-1:0] amt;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] amt_idx;
    } sh_ctrl_t;

    function automatic logic op_uses_carry(input sh_op_e op);
        return (op == SH_RRC) || (op == SH_RLC);
    endfunction

endpackage

// File: rtl/bshift_decode.sv
module bshift_decode
    import bshift_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic [DATA_W-1:0] amt_src,
    output sh_ctrl_t          ctrl
);
    logic              imm_sel;
    logic [AMT_W-1:0]  imm_amt;
    logic [AMT_W-1:0]  reg_amt;

    assign imm_sel = insn[IMM_BIT];
    assign imm_amt = insn[AMT_LSB +: AMT_W];
    assign reg_amt = amt_src[AMT_W-1:0];

    always_comb begin
        ctrl         = '0;
        ctrl.hit     = (insn[GRP_LSB +: 4] == GRP_SHIFT);
        ctrl.op      = sh_op_e'(insn[OP_W-1:0]);
        ctrl.amt     = imm_sel ? imm_amt : reg_amt;
        ctrl.dst     = insn[DST_LSB +: IDX_W];
        ctrl.amt_idx = insn[AMT_LSB +: IDX_W];
    end
endmodule

// File: rtl/bshift_rotator.sv
module bshift_rotator #(
    parameter int W     = 16,
    parameter int AMT_W = 4
) (
    input  logic [W-1:0]     din,
    input  logic             cin,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     ror_q,
    output logic [W-1:0]     rol_q,
    output logic [W:0]       rrc_ring,
    output logic [W:0]       rlc_ring
);
    localparam int RW = W + 1;

    logic [2*W-1:0]  dbl;
    logic [2*W-1:0]  dbl_r;
    logic [2*W-1:0]  dbl_l;
    logic [RW-1:0]   ring;
    logic [2*RW-1:0] rdbl;
    logic [2*RW-1:0] rdbl_r;
    logic [2*RW-1:0] rdbl_l;

    assign dbl    = {din, din};
    assign dbl_r  = dbl >> amt;
    assign dbl_l  = dbl << amt;
    assign ror_q  = dbl_r[W-1:0];
    assign rol_q  = dbl_l[2*W-1:W];

    assign ring     = {cin, din};
    assign rdbl     = {ring, ring};
    assign rdbl_r   = rdbl >> amt;
    assign rdbl_l   = rdbl << amt;
    assign rrc_ring = rdbl_r[RW-1:0];
    assign rlc_ring = rdbl_l[2*RW-1:RW];
endmodule

// File: rtl/bshift_datapath.sv
module bshift_datapath
    import bshift_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  sh_ctrl_t     ctrl,
    input  logic [W-1:0] opnd,
    input  logic         carry_in,
    output logic [W-1:0] result,
    output logic         carry_out
);
    logic [W-1:0] lsr_q, asr_q, lsl_q, ror_q, rol_q;
    logic [W:0]   rrc_ring, rlc_ring;
    logic         zero_amt;

    assign zero_amt = (ctrl.amt == '0);
    assign lsr_q    = opnd >> ctrl.amt;
    assign asr_q    = W'($signed(opnd) >>> ctrl.amt);
    assign lsl_q    = opnd << ctrl.amt;

    bshift_rotator #(.W(W), .AMT_W(AMT_W)) u_rot (
        .din      (opnd),
        .cin      (carry_in),
        .amt      (ctrl.amt),
        .ror_q    (ror_q),
        .rol_q    (rol_q),
        .rrc_ring (rrc_ring),
        .rlc_ring (rlc_ring)
    );

    always_comb begin
        result    = opnd;
        carry_out = carry_in;
        if (!zero_amt) begin
            unique case (ctrl.op)
                SH_LSR:  result = lsr_q;
                SH_ASR:  result = asr_q;
                SH_LSL:  result = lsl_q;
                SH_ROR:  result = ror_q;
                SH_ROL:  result = rol_q;
                SH_RRC:  {carry_out, result} = rrc_ring;
                SH_RLC:  {carry_out, result} = rlc_ring;
                SH_PASS: result = opnd;
                default: result = opnd;
            endcase
        end
    end
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
    import bshift_pkg::*;
(
    input  logic [15:0] insn,
    input  logic [15:0] opnd,
    input  logic [15:0] amt_src,
    input  logic        carry_in,
    output logic [15:0] result,
    output logic        carry_out,
    output logic        wr_en,
    output logic [3:0]  dst_idx,
    output logic [3:0]  amt_idx
);
    sh_ctrl_t ctrl;

    bshift_decode u_dec (
        .insn    (insn),
        .amt_src (amt_src),
        .ctrl    (ctrl)
    );

    bshift_datapath #(.W(DATA_W)) u_dp (
        .ctrl      (ctrl),
        .opnd      (opnd),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out)
    );

    assign wr_en   = ctrl.hit;
    assign dst_idx = ctrl.dst;
    assign amt_idx = ctrl.amt_idx;
endmodule

// File: rtl/bshift_chk.sv
module bshift_chk (
    input logic [15:0] insn,
    input logic [15:0] opnd,
    input logic [15:0] amt_src,
    input logic        carry_in,
    input logic [15:0] result,
    input logic        carry_out,
    input logic        wr_en
);
    logic [3:0]  n;
    logic [2:0]  code;
    logic [15:0] hi_mask;
    logic [15:0] lo_mask;
    logic        grp;

    assign grp     = (insn[15:12] == 4'h7);
    assign n       = insn[3] ? insn[7:4] : amt_src[3:0];
    assign code    = insn[2:0];
    assign hi_mask = ~(16'hFFFF >> n);
    assign lo_mask = ~(16'hFFFF << n);

    always_comb begin
        if (grp && n == 4'd0) begin
            a_r3_zero_amount: assert (result == opnd && carry_out == carry_in);
        end
        if (grp && n != 4'd0 && code == 3'd0) begin
            a_r4_lsr_zero_fill: assert ((result & hi_mask) == 16'h0000);
        end
        if (grp && n != 4'd0 && code == 3'd1) begin
            a_r5_asr_sign_fill: assert ((result & hi_mask) == (opnd[15] ? hi_mask : 16'h0000)
                                        && result[15] == opnd[15]);
        end
        if (grp && n != 4'd0 && code == 3'd2) begin
            a_r6_lsl_zero_fill: assert ((result & lo_mask) == 16'h0000);
        end
        if (grp && (code == 3'd3 || code == 3'd4)) begin
            a_r7_rot_population: assert ($countones(result) == $countones(opnd));
        end
        if (grp && (code == 3'd5 || code == 3'd6)) begin
            a_r8_r9_ring_population: assert (($countones(result) + 32'(carry_out))
                                             == ($countones(opnd) + 32'(carry_in)));
        end
        if (grp && code == 3'd7) begin
            a_r10_pass_through: assert (result == opnd && carry_out == carry_in);
        end
        if (grp && code <= 3'd4) begin
            a_r11_carry_kept: assert (carry_out == carry_in);
        end
        if (!grp) begin
            a_r1_no_write: assert (!wr_en);
        end
    end
endmodule

bind bshift_unit bshift_chk u_chk (
    .insn      (insn),
    .opnd      (opnd),
    .amt_src   (amt_src),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out),
    .wr_en     (wr_en)
);

// File: tb/bshift_unit_bench.sv
module bshift_unit_bench;
    // vector: {insn, opnd, amt_src, carry_in, exp_result, exp_carry}
    localparam int NV = 22;
    localparam logic [65:0] VEC [NV] = '{
        {16'h7148, 16'hB3C5, 16'h0000, 1'b1, 16'h0B3C, 1'b1}, // R4 lsr imm 4, R11
        {16'h7149, 16'hB3C5, 16'h0000, 1'b0, 16'hFB3C, 1'b0}, // R5 asr imm 4
        {16'h714A, 16'hB3C5, 16'h0000, 1'b1, 16'h3C50, 1'b1}, // R6 lsl imm 4
        {16'h714B, 16'hB3C5, 16'h0000, 1'b0, 16'h5B3C, 1'b0}, // R7 ror imm 4
        {16'h714C, 16'hB3C5, 16'h0000, 1'b1, 16'h3C5B, 1'b1}, // R7 rol imm 4
        {16'h714D, 16'hB3C5, 16'h0000, 1'b1, 16'hBB3C, 1'b0}, // R8 rrc imm 4
        {16'h714E, 16'hB3C5, 16'h0000, 1'b0, 16'h3C55, 1'b1}, // R9 rlc imm 4
        {16'h7235, 16'hB3C5, 16'hFFF1, 1'b0, 16'h59E2, 1'b1}, // R8 R2 rrc reg n=1
        {16'h7236, 16'hB3C5, 16'h000F, 1'b1, 16'hECF1, 1'b0}, // R9 R2 rlc reg n=15
        {16'h710A, 16'hB3C5, 16'h0000, 1'b1, 16'hB3C5, 1'b1}, // R3 lsl imm 0
        {16'h7235, 16'hB3C5, 16'h00F0, 1'b0, 16'hB3C5, 1'b0}, // R3 R2 reg amount 0
        {16'h7106, 16'hB3C5, 16'h0000, 1'b1, 16'hB3C5, 1'b1}, // R3 rlc reg 0
        {16'h7147, 16'hB3C5, 16'h0000, 1'b1, 16'hB3C5, 1'b1}, // R10 code 7
        {16'h714F, 16'hB3C5, 16'h0000, 1'b0, 16'hB3C5, 1'b0}, // R10 code F
        {16'h7231, 16'h7F00, 16'h0008, 1'b1, 16'h007F, 1'b1}, // R5 asr positive
        {16'h71F8, 16'h8001, 16'h0000, 1'b0, 16'h0001, 1'b0}, // R4 lsr 15
        {16'h71FA, 16'h8001, 16'h0000, 1'b1, 16'h8000, 1'b1}, // R6 lsl 15
        {16'h71F9, 16'h8001, 16'h0000, 1'b0, 16'hFFFF, 1'b0}, // R5 asr 15
        {16'h711B, 16'h8001, 16'h0000, 1'b0, 16'hC000, 1'b0}, // R7 ror 1
        {16'h71FC, 16'h8001, 16'h0000, 1'b1, 16'hC000, 1'b1}, // R7 rol 15
        {16'h71FD, 16'h8001, 16'h0000, 1'b0, 16'h0005, 1'b0}, // R8 rrc 15
        {16'h7232, 16'h00FF, 16'hABC4, 1'b0, 16'h0FF0, 1'b0}  // R2 R6 upper amt bits ignored
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] insn = 16'h0000;
    logic [15:0] opnd = 16'h0000;
    logic [15:0] amt_src = 16'h0000;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        carry_out;
    logic        wr_en;
    logic [3:0]  dst_idx;
    logic [3:0]  amt_idx;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    bshift_unit u_bshift_unit (
        .insn      (insn),
        .opnd      (opnd),
        .amt_src   (amt_src),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out),
        .wr_en     (wr_en),
        .dst_idx   (dst_idx),
        .amt_idx   (amt_idx)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] i, input logic [15:0] a,
                         input logic [15:0] s, input logic c);
        @(negedge clk);
        insn = i; opnd = a; amt_src = s; carry_in = c;
        #5;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset idle wr_en", 32'(wr_en), 32'd0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][65:50], VEC[k][49:34], VEC[k][33:18], VEC[k][17]);
            check($sformatf("R4-group vec %0d result", k), 32'(result), 32'(VEC[k][16:1]));
            check($sformatf("R11/R8/R9 vec %0d carry", k), 32'(carry_out), 32'(VEC[k][0]));
            check("R1 wr_en in group", 32'(wr_en), 32'd1);
        end

        // R1: destination and non-group decode
        apply(16'h7A5B, 16'h1234, 16'h0000, 1'b0);
        check("R1 dst_idx", 32'(dst_idx), 32'hA);
        check("R2 amt_idx", 32'(amt_idx), 32'h5);
        apply(16'h6148, 16'hB3C5, 16'h0000, 1'b1);
        check("R1 other group no write", 32'(wr_en), 32'd0);
        apply(16'hF148, 16'hB3C5, 16'h0000, 1'b1);
        check("R1 group F no write", 32'(wr_en), 32'd0);

        // R2: immediate selected ignores the amount register
        apply(16'h7128, 16'h0001, 16'h0007, 1'b0);
        check("R2 immediate wins", 32'(result), 32'h0000);
        apply(16'h712A, 16'h0001, 16'h0007, 1'b0);
        check("R2 immediate lsl 2", 32'(result), 32'h0004);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule